// File: doc/BRIEF.md
# Serial Audio Justification Converter

This block sits on a serial audio link between a source and a sink that place a sample differently inside the 32-bit channel slot. It carries bit clock, word clock, channel-select clock and MSB-first serial data. It moves the channel boundary by a quarter of the channel-select period, which is 16 bit clocks. The move is made by re-sampling the channel-select clock on each rising edge of the word clock. The serial data and both clocks pass through untouched. One right-justified 16-bit stream therefore leaves as left-justified, and a left-justified 24-bit stream leaves as right-justified 16-bit framing.

A receive path inside the block shifts the serial data into a 16-bit register and copies it to a per-channel parallel output on each channel-select transition. In right-to-left mode the copy follows the incoming transitions. In left-to-right mode it follows the delayed transitions. A static mode input selects between the two, and a status output reports which framing the outgoing stream follows.

A word-clock spacing monitor counts bit-clock rising edges. It flags every word-clock edge that does not arrive exactly half a slot after the previous one. All inputs are sampled by a fast system clock through a short synchronizer. Their relative timing is kept, so the outputs follow the inputs a fixed number of system clocks later.

Top module: `justify_conv`

## Requirements
- R1: `lrclk_out` changes only on a word-clock rising edge. During bit positions 0..15 of a slot it holds the channel-select level of the previous slot. During positions 16..31 it holds the level of the current slot.
- R2: `sdata_out`, `bclk_out` and `wclk_out` equal the corresponding inputs, delayed by SYNC_STAGES system clocks, with no change in value.
- R3: In mode 0 (right-to-left), the 16 bits that arrive last before a transition of `lrclk_in` are copied on that transition. They go to `sample_left` if `lrclk_in` was 0 and to `sample_right` if it was 1. A right-justified word in slot positions 16..31 is therefore captured whole, and the pad bits are discarded.
- R4: In mode 1 (left-to-right), the copy happens on each transition of `lrclk_out` and goes to the channel of the current input slot. The captured word is the top 16 bits of a left-justified 24-bit word in slot positions 0..15. Slot bits from position 16 onward do not disturb it.
- R5: Bits are MSB first. The earliest of the 16 captured bits lands in bit 15 of the sample.
- R6: An active-low asynchronous reset clears both samples, `lrclk_out`, `sample_stb` and `wclk_err`.
- R7: The first copy event after reset is invalid. It loads neither sample and raises no strobe.
- R8: `sample_stb` is a one-cycle pulse for each valid copy. Only one channel's sample changes per copy, and a sample changes only in a strobe cycle.
- R9: `wclk_err` pulses for one cycle when a word-clock edge arrives after a number of bit-clock rising edges other than 16 since the previous word-clock edge. The first word-clock edge after reset is not judged.
- R10: When a bit-clock rising edge and a copy event land in the same system cycle, the copied sample holds the 16 bits taken before that cycle. The bit taken in that cycle starts the next word.
- R11: `out_left_just` is 1 in mode 0 and 0 in mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the audio link |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_l2r | input | 1 | 0 = right-to-left conversion, 1 = left-to-right conversion |
| bclk_in | input | 1 | Incoming bit clock |
| wclk_in | input | 1 | Incoming word clock, toggles every 16 bit clocks |
| lrclk_in | input | 1 | Incoming channel select, 0 = left, 1 = right |
| sdata_in | input | 1 | Incoming serial data, MSB first |
| bclk_out | output | 1 | Bit clock passed through |
| wclk_out | output | 1 | Word clock passed through |
| lrclk_out | output | 1 | Channel select delayed by one word-clock rising edge |
| sdata_out | output | 1 | Serial data passed through |
| out_left_just | output | 1 | 1 when the outgoing framing is left-justified |
| sample_left | output | 16 | Last valid left-channel sample |
| sample_right | output | 16 | Last valid right-channel sample |
| sample_stb | output | 1 | One-cycle pulse on each valid sample copy |
| wclk_err | output | 1 | One-cycle pulse on a mis-spaced word-clock edge |

## Verification
Two functions can land in the same system cycle: shifting a serial bit on a bit-clock rising edge, and copying the shift register on a channel-select transition. The bench provokes this by moving one `lrclk_in` transition forward two system clocks. The transition then shares its cycle with the rising bit-clock edge of the slot's last bit. The test is judged at the ports. After a right-justified word 0xA5C3 preceded by a zero pad bit, the left sample must read 0x52E1, which is the word shifted right by one. A value of 0xA5C3 would mean the concurrent bit leaked into the copy.

// File: rtl/jc_pkg.sv
package jc_pkg;

  // Direction of the justification change
  typedef enum logic {
    MODE_R2L = 1'b0,   // right-justified in, left-justified out
    MODE_L2R = 1'b1    // left-justified in, right-justified out
  } jc_mode_e;

  // A word-clock edge is mis-spaced when the bit-clock count since the
  // previous edge differs from half a slot.
  function automatic logic spacing_bad(input logic [31:0] cnt,
                                       input logic [31:0] half);
    return cnt != half;
  endfunction

  // Channel a copied word belongs to. On an input transition the word
  // belongs to the slot just ended (old level). On a delayed transition
  // it belongs to the slot now running (new delayed level).
  function automatic logic pick_right(input jc_mode_e m,
                                      input logic     lr_before_edge,
                                      input logic     lr_delayed_now);
    return (m == MODE_R2L) ? lr_before_edge : lr_delayed_now;
  endfunction

  // Output framing reported for a mode
  function automatic logic framing_is_left(input jc_mode_e m);
    return m == MODE_R2L;
  endfunction

endpackage

// File: rtl/jc_sync.sv
module jc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/jc_frame.sv
module jc_frame
  import jc_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  input  logic wclk_s,
  input  logic lr_s,
  output logic lr_dly,
  output logic lr_prev,
  output logic bclk_rise_ev,
  output logic wc_rise_ev,
  output logic wc_edge_ev,
  output logic raw_lr_ev,
  output logic dly_lr_ev,
  output logic spacing_err
);

  localparam int unsigned HALF = SLOT_BITS / 2;
  localparam int          CW   = $clog2(SLOT_BITS) + 1;

  logic          bclk_q;
  logic          wclk_q;
  logic          lr_dly_q;
  logic          armed;
  logic [CW-1:0] bcnt;

  // previous-cycle copies for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      wclk_q  <= 1'b0;
      lr_prev <= 1'b0;
    end else begin
      bclk_q  <= bclk_s;
      wclk_q  <= wclk_s;
      lr_prev <= lr_s;
    end
  end

  assign bclk_rise_ev = bclk_s & ~bclk_q;
  assign wc_rise_ev   = wclk_s & ~wclk_q;
  assign wc_edge_ev   = wclk_s ^ wclk_q;
  assign raw_lr_ev    = lr_s ^ lr_prev;

  // channel select re-timed by the word clock: a quarter period late
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_dly   <= 1'b0;
      lr_dly_q <= 1'b0;
    end else begin
      if (wc_rise_ev) lr_dly <= lr_s;
      lr_dly_q <= lr_dly;
    end
  end

  assign dly_lr_ev = lr_dly ^ lr_dly_q;

  // word-clock spacing monitor, counted in bit-clock rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt        <= '0;
      armed       <= 1'b0;
      spacing_err <= 1'b0;
    end else if (wc_edge_ev) begin
      spacing_err <= armed & spacing_bad(32'(bcnt), 32'(HALF));
      bcnt        <= '0;
      armed       <= 1'b1;
    end else begin
      spacing_err <= 1'b0;
      if (bclk_rise_ev && (bcnt != '1)) bcnt <= bcnt + 1'b1;
    end
  end

endmodule

// File: rtl/jc_rx.sv
module jc_rx #(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_ev,
  input  logic                 bit_in,
  input  logic                 latch_ev,
  input  logic                 latch_right,
  output logic [WORD_BITS-1:0] word_left,
  output logic [WORD_BITS-1:0] word_right,
  output logic                 word_stb
);

  logic [WORD_BITS-1:0] sr;
  logic                 armed;

  // MSB-first shift: the oldest of the last WORD_BITS bits ends on top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (shift_ev) sr <= {sr[WORD_BITS-2:0], bit_in};
  end

  // copy stage; the first copy after reset only arms it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_left  <= '0;
      word_right <= '0;
      word_stb   <= 1'b0;
      armed      <= 1'b0;
    end else begin
      word_stb <= latch_ev & armed;
      if (latch_ev) begin
        armed <= 1'b1;
        if (armed) begin
          if (latch_right) word_right <= sr;
          else             word_left  <= sr;
        end
      end
    end
  end

endmodule

// File: rtl/justify_conv.sv
module justify_conv
  import jc_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int WORD_BITS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_l2r,
  input  logic                 bclk_in,
  input  logic                 wclk_in,
  input  logic                 lrclk_in,
  input  logic                 sdata_in,
  output logic                 bclk_out,
  output logic                 wclk_out,
  output logic                 lrclk_out,
  output logic                 sdata_out,
  output logic                 out_left_just,
  output logic [WORD_BITS-1:0] sample_left,
  output logic [WORD_BITS-1:0] sample_right,
  output logic                 sample_stb,
  output logic                 wclk_err
);

  localparam int NSIG = 4;

  jc_mode_e        mode;
  logic [NSIG-1:0] link_raw;
  logic [NSIG-1:0] link_s;
  logic            bclk_s, wclk_s, lr_s, sd_s;

  // named internal events, brought out for the checker
  logic lr_dly, lr_prev;
  logic bclk_rise_ev, wc_rise_ev, wc_edge_ev;
  logic raw_lr_ev, dly_lr_ev;
  logic latch_ev, latch_right;

  assign mode     = jc_mode_e'(mode_l2r);
  assign link_raw = {sdata_in, lrclk_in, wclk_in, bclk_in};

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      jc_sync #(.STAGES(SYNC_STAGES), .W(NSIG)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .d   (link_raw),
        .q   (link_s)
      );
    end else begin : g_nosync
      assign link_s = link_raw;
    end
  endgenerate

  assign {sd_s, lr_s, wclk_s, bclk_s} = link_s;

  jc_frame #(.SLOT_BITS(SLOT_BITS)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_s      (bclk_s),
    .wclk_s      (wclk_s),
    .lr_s        (lr_s),
    .lr_dly      (lr_dly),
    .lr_prev     (lr_prev),
    .bclk_rise_ev(bclk_rise_ev),
    .wc_rise_ev  (wc_rise_ev),
    .wc_edge_ev  (wc_edge_ev),
    .raw_lr_ev   (raw_lr_ev),
    .dly_lr_ev   (dly_lr_ev),
    .spacing_err (wclk_err)
  );

  // copy on the transitions of whichever channel select is right-justified
  assign latch_ev    = (mode == MODE_R2L) ? raw_lr_ev : dly_lr_ev;
  assign latch_right = pick_right(mode, lr_prev, lr_dly);

  jc_rx #(.WORD_BITS(WORD_BITS)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_ev   (bclk_rise_ev),
    .bit_in     (sd_s),
    .latch_ev   (latch_ev),
    .latch_right(latch_right),
    .word_left  (sample_left),
    .word_right (sample_right),
    .word_stb   (sample_stb)
  );

  assign bclk_out      = bclk_s;
  assign wclk_out      = wclk_s;
  assign sdata_out     = sd_s;
  assign lrclk_out     = lr_dly;
  assign out_left_just = framing_is_left(mode);

endmodule

// File: rtl/jc_checker.sv
module jc_checker #(
  parameter int WORD_BITS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lrclk_out,
  input logic                 wc_rise_ev,
  input logic                 wc_edge_ev,
  input logic [WORD_BITS-1:0] sample_left,
  input logic [WORD_BITS-1:0] sample_right,
  input logic                 sample_stb,
  input logic                 wclk_err
);

  // R1
  lr_moves_on_wclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk_out) |-> $past(wc_rise_ev));

  // R8
  left_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_left) |-> sample_stb);

  // R8
  right_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_right) |-> sample_stb);

  // R8
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_left) |-> $stable(sample_right));

  // R8
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R9
  err_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wclk_err |-> $past(wc_edge_ev));

endmodule

bind justify_conv jc_checker #(.WORD_BITS(WORD_BITS)) u_jc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lrclk_out   (lrclk_out),
  .wc_rise_ev  (wc_rise_ev),
  .wc_edge_ev  (wc_edge_ev),
  .sample_left (sample_left),
  .sample_right(sample_right),
  .sample_stb  (sample_stb),
  .wclk_err    (wclk_err)
);

// File: tb/justify_conv_bench.sv
module justify_conv_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_l2r = 1'b0;
  logic        bclk_in = 1'b0, wclk_in = 1'b0, lrclk_in = 1'b0, sdata_in = 1'b0;
  logic        bclk_out, wclk_out, lrclk_out, sdata_out, out_left_just;
  logic [15:0] sample_left, sample_right;
  logic        sample_stb, wclk_err;

  int n_chk = 0;
  int n_bad = 0;
  int stb_cnt = 0;
  int err_cnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  justify_conv u_justify_conv (
    .clk(clk), .rst_n(rst_n), .mode_l2r(mode_l2r),
    .bclk_in(bclk_in), .wclk_in(wclk_in), .lrclk_in(lrclk_in), .sdata_in(sdata_in),
    .bclk_out(bclk_out), .wclk_out(wclk_out), .lrclk_out(lrclk_out), .sdata_out(sdata_out),
    .out_left_just(out_left_just), .sample_left(sample_left), .sample_right(sample_right),
    .sample_stb(sample_stb), .wclk_err(wclk_err)
  );

  always @(posedge clk) begin
    if (sample_stb) stb_cnt <= stb_cnt + 1;
    if (wclk_err)   err_cnt <= err_cnt + 1;
  end

  // {mode, left slot, right slot, expected left, expected right}
  localparam logic [96:0] VEC [6] = '{
    {1'b0, 32'h0000_1234, 32'h0000_8001, 16'h1234, 16'h8001},
    {1'b0, 32'hFFFF_00FF, 32'hA5A5_FFFF, 16'h00FF, 16'hFFFF},
    {1'b1, 32'hDEAD_BEEF, 32'h7F00_0000, 16'hDEAD, 16'h7F00},
    {1'b1, 32'h0001_FFFF, 32'hFFFE_0000, 16'h0001, 16'hFFFE},
    {1'b0, 32'h1357_9BDF, 32'h2468_ACE0, 16'h9BDF, 16'hACE0},
    {1'b1, 32'h8000_0001, 32'h0000_8000, 16'h8000, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bclk_in = 1'b0; wclk_in = 1'b0; lrclk_in = 1'b0; sdata_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one 32-bit slot, 4 system clocks per bit; probes taken at bits 8 and 24
  task automatic send_slot(input logic lr, input logic [31:0] data,
                           input bit bad_wc, input bit late_lr,
                           output logic p_early, output logic p_late,
                           output logic p_dat, output logic p_bc, output logic p_wc);
    p_early = 1'b0; p_late = 1'b0; p_dat = 1'b0; p_bc = 1'b0; p_wc = 1'b0;
    for (int b = 0; b < 32; b++) begin
      bclk_in  = 1'b0;
      sdata_in = data[31-b];
      wclk_in  = bad_wc ? (b >= 15) : (b >= 16);
      lrclk_in = lr;
      @(negedge clk);
      @(negedge clk);
      bclk_in = 1'b1;
      if (late_lr && b == 31) lrclk_in = ~lr;
      @(negedge clk);
      @(negedge clk);
      if (b == 8) p_early = lrclk_out;
      if (b == 24) begin
        p_late = lrclk_out; p_dat = sdata_out; p_bc = bclk_out; p_wc = wclk_out;
      end
    end
  endtask

  task automatic send_frame(input logic [31:0] l, input logic [31:0] r);
    logic a, b, c, d, e;
    send_slot(1'b0, l, 1'b0, 1'b0, a, b, c, d, e);
    send_slot(1'b1, r, 1'b0, 1'b0, a, b, c, d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic e0, l0, d0, b0, w0, e1, l1, d1, b1, w1;
    int   base;

    do_reset();
    // R6 reset state
    chk("R6 left after reset", 32'(sample_left), 32'h0);
    chk("R6 right after reset", 32'(sample_right), 32'h0);
    chk("R6 lrclk_out after reset", 32'(lrclk_out), 32'h0);
    chk("R6 stb after reset", 32'(sample_stb), 32'h0);
    chk("R6 err after reset", 32'(wclk_err), 32'h0);

    // R11 framing flag per mode
    mode_l2r = 1'b1; #1;
    chk("R11 flag in mode 1", 32'(out_left_just), 32'h0);
    mode_l2r = 1'b0; #1;
    chk("R11 flag in mode 0", 32'(out_left_just), 32'h1);

    // table walk: R3 / R4 / R5
    base = err_cnt;
    for (int i = 0; i < 6; i++) begin
      mode_l2r = VEC[i][96];
      repeat (3) send_frame(VEC[i][95:64], VEC[i][63:32]);
      if (VEC[i][96]) begin
        chk($sformatf("R4 R5 vec%0d left", i), 32'(sample_left), 32'(VEC[i][31:16]));
        chk($sformatf("R4 R5 vec%0d right", i), 32'(sample_right), 32'(VEC[i][15:0]));
      end else begin
        chk($sformatf("R3 R5 vec%0d left", i), 32'(sample_left), 32'(VEC[i][31:16]));
        chk($sformatf("R3 R5 vec%0d right", i), 32'(sample_right), 32'(VEC[i][15:0]));
      end
    end
    chk("R9 no error on regular word clock", 32'(err_cnt - base), 32'h0);

    // R1 quarter-period delay and R2 pass-through
    mode_l2r = 1'b0;
    send_slot(1'b0, 32'h0000_0080, 1'b0, 1'b0, e0, l0, d0, b0, w0);
    send_slot(1'b1, 32'hFFFF_FF7F, 1'b0, 1'b0, e1, l1, d1, b1, w1);
    chk("R1 left slot early half", 32'(e0), 32'h1);
    chk("R1 left slot late half", 32'(l0), 32'h0);
    chk("R1 right slot early half", 32'(e1), 32'h0);
    chk("R1 right slot late half", 32'(l1), 32'h1);
    chk("R2 data pass-through", {30'h0, d0, d1}, {30'h0, 1'b1, 1'b0});
    chk("R2 clock pass-through", {30'h0, b0, w0}, 32'h3);

    // R9 mis-spaced word clock: early rise and the long gap after it
    base = err_cnt;
    send_slot(1'b0, 32'h0, 1'b1, 1'b0, e0, l0, d0, b0, w0);
    send_slot(1'b1, 32'h0, 1'b0, 1'b0, e1, l1, d1, b1, w1);
    chk("R9 mis-spaced edges flagged", 32'(err_cnt - base), 32'h2);

    // R10 copy and shift in the same cycle
    mode_l2r = 1'b0;
    repeat (2) send_frame(32'h0000_A5C3, 32'h0000_0F0F);
    chk("R10 setup left", 32'(sample_left), 32'h0000_A5C3);
    send_slot(1'b0, 32'h0000_A5C3, 1'b0, 1'b1, e0, l0, d0, b0, w0);
    send_slot(1'b1, 32'h0000_0F0F, 1'b0, 1'b0, e1, l1, d1, b1, w1);
    chk("R10 concurrent bit excluded", 32'(sample_left), 32'h0000_52E1);

    // R6 mid-run reset, R7 first copy dropped, R8 strobe count
    do_reset();
    chk("R6 left after second reset", 32'(sample_left), 32'h0);
    chk("R6 right after second reset", 32'(sample_right), 32'h0);
    base = stb_cnt;
    send_frame(32'h0000_1111, 32'h0000_2222);
    chk("R7 no strobe for first copy", 32'(stb_cnt - base), 32'h0);
    chk("R7 first copy not loaded", 32'(sample_left), 32'h0);
    send_frame(32'h0000_1111, 32'h0000_2222);
    chk("R8 one strobe per copy", 32'(stb_cnt - base), 32'h2);
    chk("R3 left after reset", 32'(sample_left), 32'h1111);
    chk("R3 right after reset", 32'(sample_right), 32'h2222);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule